// File: doc/BRIEF.md
# External Clock Pin Synchronizer

This block takes a free-running, asynchronous signal from a package pin and turns it into count-enable pulses for a timer in the system clock domain. The pin passes through two stages. The first stage captures on the falling edge of the system clock, so it takes the value the pin held during the preceding high phase. A register clocked on the rising edge follows it. That rising-edge register drives the synchronized level output. A delayed copy of this level feeds an edge detector, and the detector registers a one-cycle pulse for each edge of the chosen polarity.

A 3-bit clock-select code picks the polarity. Code 7 counts rising edges and code 6 counts falling edges. Every other code turns the detector off, and while it is off the pulse output stays low. The synchronized level follows the pin whatever the select code is. Because the delay passes through a half-cycle stage and a full register, a counter that consumes the pulse updates between 2.5 and 3.5 system clock cycles after the pin edge. Where the pin moves within the clock period decides the exact figure.

The select code must change only while the pin has been steady. If the pin has just moved, the detector may still be holding an edge that was seen while counting was off, and that edge turns into a pulse once counting is switched on.

Top module: `ext_clk_sync`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released with the pin low, `sync_lvl` and `edge_pulse` are 0.
- R2: A pin change made during the high phase of the clock shows up on `sync_lvl` after the next rising edge. `sync_lvl` follows the pin for every select code.
- R3: `edge_pulse` is registered on the second rising edge after a pin change made in the clock's high phase. It is registered on the third rising edge after a change made in the low phase. A counter that samples the pulse therefore updates 2.5 to 3.5 cycles after the pin edge.
- R4: With `clk_sel` = 3'b111, each low-to-high pin transition gives exactly one pulse and high-to-low transitions give none.
- R5: With `clk_sel` = 3'b110, each high-to-low pin transition gives exactly one pulse and low-to-high transitions give none.
- R6: With any other `clk_sel` value, `edge_pulse` stays 0 whatever the pin does.
- R7: Switching `clk_sel` to 3'b110 or 3'b111 while the pin has been steady for at least three cycles gives no pulse.
- R8: The pulse decision uses the `clk_sel` value present in the cycle before the rising edge that registers the pulse. A select change made in that cycle therefore decides whether a pending edge is counted.
- R9: `edge_pulse` is never high for two cycles in a row. A pin pulse one cycle wide, or pin edges two cycles apart, each still give their own pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous external clock pin |
| clk_sel | input | 3 | Clock-select code: 7 counts rising edges, 6 counts falling edges, any other value disables the detector |
| sync_lvl | output | 1 | Pin level after synchronization |
| edge_pulse | output | 1 | One-cycle count-enable pulse |

## Verification
A change of polarity or enable can fall in the same cycle in which the detector holds a pending edge. The bench provokes this by raising the pin during a high phase and then rewriting `clk_sel` just after the next rising edge, while the new level is on `sync_lvl` and its delayed copy is still old. The scoreboard expects a pulse only if the newly written code selects that edge's polarity. It also expects nothing when counting is switched on over a steady pin.

// File: rtl/ext_clk_sync.sv
module ext_clk_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_raw,
  input  logic [2:0] clk_sel,
  output logic       sync_lvl,
  output logic       edge_pulse
);

  localparam logic [2:0] SEL_FALL = 3'd6;
  localparam logic [2:0] SEL_RISE = 3'd7;

  logic half_q;
  logic lvl_q;
  logic lvl_d1;
  logic hit;

  // front stage: captures the pin as the clock falls, i.e. what it held during the high phase
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= pin_raw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q      <= 1'b0;
      lvl_d1     <= 1'b0;
      edge_pulse <= 1'b0;
    end else begin
      lvl_q      <= half_q;
      lvl_d1     <= lvl_q;
      edge_pulse <= hit;
    end

  assign hit = (clk_sel == SEL_RISE) ? (lvl_q & ~lvl_d1) :
               (clk_sel == SEL_FALL) ? (~lvl_q & lvl_d1) : 1'b0;

  assign sync_lvl = lvl_q;

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);

  a_r4_rise_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'b111) && sync_lvl && !$past(sync_lvl) |=> edge_pulse);

  a_r5_fall_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'b110) && !sync_lvl && $past(sync_lvl) |=> edge_pulse);

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_sel[2] && clk_sel[1]) |=> !edge_pulse);

  a_r7_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |-> ($past(sync_lvl) != $past(sync_lvl, 2)));

endmodule

// File: tb/ext_clk_sync_tb.sv
`timescale 1ns/100ps
module ext_clk_sync_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_raw = 1'b0;
  logic [2:0] clk_sel = 3'd7;
  logic       sync_lvl;
  logic       edge_pulse;

  typedef struct {
    int    cyc;
    string req;
  } exp_t;

  exp_t  q[$];
  int    cyc = 0;
  int    vectors = 0;
  int    fails = 0;
  bit    run = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  ext_clk_sync u_dut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .clk_sel(clk_sel),
    .sync_lvl(sync_lvl), .edge_pulse(edge_pulse)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard monitor: compares edge_pulse every cycle against the queue
  always @(posedge clk) begin
    logic exp_p;
    string r;
    #1;
    if (run) begin
      exp_p = (q.size() > 0) && (q[0].cyc == cyc);
      r = exp_p ? q[0].req : cur_req;
      vectors++;
      if (edge_pulse !== exp_p) begin
        fails++;
        $display("FAIL %s edge_pulse cycle %0d: got %b expected %b", r, cyc, edge_pulse, exp_p);
      end
      if (exp_p) void'(q.pop_front());
    end
  end

  task automatic check(input string req, input logic act, input logic expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, expv);
    end
  endtask

  task automatic drive_pin(input logic v, input bit low_phase, input bit expect_p, input string req);
    int c;
    @(posedge clk);
    if (low_phase) #2.5; else #0.5;
    c = cyc;
    pin_raw = v;
    cur_req = req;
    if (expect_p) q.push_back('{c + (low_phase ? 3 : 2), req});
  endtask

  task automatic set_sel(input logic [2:0] s);
    @(posedge clk);
    #0.5;
    clk_sel = s;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1;
    check("R1 in reset sync_lvl", sync_lvl, 1'b0);
    check("R1 in reset edge_pulse", edge_pulse, 1'b0);
    @(posedge clk); #0.5; rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release sync_lvl", sync_lvl, 1'b0);
    check("R1 after release edge_pulse", edge_pulse, 1'b0);
    run = 1'b1;
    idle(3);

    // R2 R3 R4: rising mode, high-phase change
    clk_sel = 3'd7;
    drive_pin(1'b1, 1'b0, 1'b1, "R4");
    @(posedge clk); #1;
    check("R2 level after one edge", sync_lvl, 1'b1);
    idle(5);
    drive_pin(1'b0, 1'b0, 1'b0, "R4");
    @(posedge clk); #1;
    check("R2 level falls", sync_lvl, 1'b0);
    idle(5);
    // R3 low-phase change: one cycle later
    drive_pin(1'b1, 1'b1, 1'b1, "R3");
    idle(6);
    drive_pin(1'b0, 1'b1, 1'b0, "R3");
    idle(6);

    // R5 falling mode
    set_sel(3'd6);
    idle(3);
    drive_pin(1'b1, 1'b0, 1'b0, "R5");
    idle(5);
    drive_pin(1'b0, 1'b0, 1'b1, "R5");
    idle(5);
    drive_pin(1'b1, 1'b1, 1'b0, "R5");
    idle(5);
    drive_pin(1'b0, 1'b1, 1'b1, "R5");
    idle(6);

    // R6 disabled codes; level still tracks
    foreach (q[i]) ;
    for (int s = 0; s < 6; s++) begin
      set_sel(3'(s));
      idle(3);
      drive_pin(1'b1, 1'b0, 1'b0, "R6");
      @(posedge clk); #1;
      check("R6 level tracks while disabled", sync_lvl, 1'b1);
      idle(4);
      drive_pin(1'b0, 1'b1, 1'b0, "R6");
      idle(4);
      #1;
      check("R6 level low while disabled", sync_lvl, 1'b0);
    end

    // R7 enabling over steady pin
    set_sel(3'd0);
    drive_pin(1'b1, 1'b0, 1'b0, "R7");
    idle(5);
    set_sel(3'd7);
    idle(4);
    set_sel(3'd6);
    idle(4);
    set_sel(3'd0);
    drive_pin(1'b0, 1'b0, 1'b0, "R7");
    idle(5);
    set_sel(3'd6);
    idle(4);
    set_sel(3'd7);
    idle(4);

    // R9 narrow pin pulses and edges two cycles apart
    drive_pin(1'b1, 1'b0, 1'b1, "R9");
    drive_pin(1'b0, 1'b0, 1'b0, "R9");
    idle(5);
    drive_pin(1'b1, 1'b0, 1'b1, "R9");
    drive_pin(1'b0, 1'b0, 1'b0, "R9");
    drive_pin(1'b1, 1'b0, 1'b1, "R9");
    drive_pin(1'b0, 1'b0, 1'b0, "R9");
    idle(6);

    // R8 select change in the cycle holding a pending edge
    drive_pin(1'b1, 1'b0, 1'b0, "R8");
    set_sel(3'd6);
    idle(5);
    drive_pin(1'b0, 1'b0, 1'b0, "R8");
    set_sel(3'd7);
    idle(5);
    set_sel(3'd6);
    idle(3);
    begin
      int c;
      drive_pin(1'b1, 1'b0, 1'b0, "R8");
      c = cyc;
      set_sel(3'd7);
      q.push_back('{c + 2, "R8"});
    end
    idle(6);

    run = 1'b0;
    vectors++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R3 pending pulses: got %0d expected 0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule